// File: doc/BRIEF.md
# ROM Mapping and Board Control Unit

This block is the memory-map glue of a small 8-bit processor board. It watches the processor's I/O bus for accesses to a four-byte window whose base is set by a configuration input. Within that window it selects the serial controller, holds a writable board control register and returns a board status word. It also watches the memory bus and decides when the ROM answers, and which 4 KB page of the ROM appears.

Two flip-flops govern the ROM. The enable flop turns ROM decoding on or off. The boot flop adds an overlay that makes the ROM answer at address zero, so that the processor can fetch its reset code from ROM. Each flop takes its reset value from its own strap input. Software clears the boot flop once its startup code has jumped to the real ROM location. A 3-bit page latch supplies the upper ROM address bits.

Top module: `rom_map_ctl`

## Requirements
- R1: An I/O access (io_rd or io_wr high) hits the window only when io_addr[7:2] equals io_base_cfg. Accesses outside the window assert no select, change no state and read 0x00.
- R2: An I/O access inside the window at offset 0 or 1 asserts serial_cs in the same cycle. serial_cs stays low at offsets 2 and 3, and io_rdata reads 0x00 at offsets 0 and 1.
- R3: While rst_n is low at a clock edge, the page latch clears to 0. The ROM enable flop loads strap_rom_en and the boot flop loads strap_boot.
- R4: An io_wr at offset 2 loads the page latch from io_wdata[7:5], the ROM enable flop from io_wdata[4] and the boot flop from io_wdata[3]. io_wdata[2:0] are ignored. The new values take effect from the cycle after the write.
- R5: An io_rd at offset 2 returns the status word {page[2:0], rom_en, boot, 3'b000}, with the page in bits 7:5, enable in bit 4 and boot in bit 3.
- R6: Offset 3 is reserved. It reads 0x00, and a write to it changes no state.
- R7: rom_cs is high when mem_req is high, ROM is enabled and cpu_addr[15:12] equals rom_base_cfg. rom_addr is always {page, cpu_addr[11:0]}.
- R8: While the boot flop and ROM enable are both set, rom_cs is also high for mem_req with cpu_addr[15:12] equal to 0. After the boot bit is cleared, address zero no longer selects ROM from the next cycle on.
- R9: While ROM enable is clear, rom_cs is never asserted, whatever the state of the boot flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_base_cfg | input | 6 | I/O window base, compared with io_addr[7:2] |
| rom_base_cfg | input | 4 | ROM page location, compared with cpu_addr[15:12] |
| strap_rom_en | input | 1 | Reset value of the ROM enable flop |
| strap_boot | input | 1 | Reset value of the boot overlay flop |
| io_addr | input | 8 | I/O port address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (status word or 0x00) |
| serial_cs | output | 1 | Serial controller select |
| cpu_addr | input | 16 | Memory address |
| mem_req | input | 1 | Memory access qualifier |
| rom_cs | output | 1 | ROM chip select |
| rom_addr | output | 15 | ROM address {page, cpu_addr[11:0]} |

## Verification
The hardest case to reach is the hand-over at the end of boot. ROM must answer at address zero and at its configured page, and then stop answering at zero in the cycle right after the boot bit is written low. This has to hold for every strap pairing, including boot strapped on with enable strapped off, where no select may appear at all. The stimulus resets under each of the four strap combinations and probes address zero and the ROM base before and after a directed clearing write. After that, random traffic biased toward the window keeps rewriting the page, enable and boot bits between random memory probes. This also covers the case where the ROM base itself is zero.

// File: rtl/rmc_pkg.sv
// Package: shared widths and the control-state type for the ROM mapping unit.
// Assumes an 8-bit I/O space and a 16-bit memory space split into 4 KB pages.
package rmc_pkg;
    localparam int IO_AW      = 8;
    localparam int WIN_BITS   = 2;
    localparam int BASE_W     = IO_AW - WIN_BITS;
    localparam int MEM_AW     = 16;
    localparam int PAGE_OFS_W = 12;
    localparam int SEG_W      = MEM_AW - PAGE_OFS_W;
    localparam int PAGE_W     = 3;
    localparam int ROM_AW     = PAGE_W + PAGE_OFS_W;
    localparam int DATA_W     = 8;

    // Window offsets; the serial controller owns the two lowest.
    localparam logic [WIN_BITS-1:0] OFS_SER0 = 2'd0;
    localparam logic [WIN_BITS-1:0] OFS_SER1 = 2'd1;
    localparam logic [WIN_BITS-1:0] OFS_CTL  = 2'd2;
    localparam logic [WIN_BITS-1:0] OFS_RSV  = 2'd3;

    // Field positions shared by the control write and the status word.
    localparam int BIT_BOOT  = 3;
    localparam int BIT_EN    = 4;
    localparam int PAGE_LSB  = 5;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              en;
        logic              boot;
    } ctl_state_t;
endpackage

// File: rtl/rmc_io_decode.sv
// I/O window decoder: compares the upper port address bits against the
// configured base and splits the four-byte window into per-offset strobes.
// Assumes io_rd and io_wr are single-cycle qualifiers from the bus side.
module rmc_io_decode
    import rmc_pkg::*;
(
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BASE_W-1:0] io_base,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic              serial_cs,
    output logic              ctl_we,
    output logic              stat_re
);
    logic              hit;
    logic [WIN_BITS-1:0] ofs;

    // Window match and offset extraction.
    always_comb begin
        hit = (io_rd | io_wr) && (io_addr[IO_AW-1:WIN_BITS] == io_base);
        ofs = io_addr[WIN_BITS-1:0];
    end

    // Per-offset strobes; the reserved offset produces none.
    always_comb begin
        serial_cs = hit && (ofs == OFS_SER0 || ofs == OFS_SER1);
        ctl_we    = hit && io_wr && (ofs == OFS_CTL);
        stat_re   = hit && io_rd && (ofs == OFS_CTL);
    end
endmodule

// File: rtl/rmc_ctl_regs.sv
// Board control state: page latch, ROM enable flop and boot overlay flop.
// The page clears on reset; both flops take strap-selected reset values.
module rmc_ctl_regs
    import rmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_rom_en,
    input  logic              strap_boot,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] wdata,
    output ctl_state_t        state
);
    ctl_state_t state_q;

    // Reset to strap defaults, otherwise load the control fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.page <= '0;
            state_q.en   <= strap_rom_en;
            state_q.boot <= strap_boot;
        end else if (ctl_we) begin
            state_q.page <= wdata[PAGE_LSB +: PAGE_W];
            state_q.en   <= wdata[BIT_EN];
            state_q.boot <= wdata[BIT_BOOT];
        end
    end

    assign state = state_q;

    AST_RESET_STRAPS: assert property (@(posedge clk)
        !rst_n |=> (state_q.page == '0 && state_q.en == $past(strap_rom_en)
                    && state_q.boot == $past(strap_boot))); // R3
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (state_q.page == $past(wdata[PAGE_LSB +: PAGE_W])
                    && state_q.en == $past(wdata[BIT_EN]))); // R4
    AST_BOOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !wdata[BIT_BOOT]) |=> !state_q.boot); // R8
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(state_q)); // R6
endmodule

// File: rtl/rmc_rom_select.sv
// ROM select: drives the ROM chip select from the upper memory address bits,
// the ROM base setting and the control flops, and forms the paged ROM address.
// Assumes mem_req qualifies cpu_addr for the whole access.
module rmc_rom_select
    import rmc_pkg::*;
(
    input  logic [MEM_AW-1:0] cpu_addr,
    input  logic              mem_req,
    input  logic [SEG_W-1:0]  rom_base,
    input  ctl_state_t        state,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr
);
    logic [SEG_W-1:0] seg;
    logic             base_hit;
    logic             boot_hit;

    // Segment compare for the normal window and the address-zero overlay.
    always_comb begin
        seg      = cpu_addr[MEM_AW-1:PAGE_OFS_W];
        base_hit = (seg == rom_base);
        boot_hit = state.boot && (seg == '0);
    end

    // Select gated by enable; the address always carries the page latch.
    always_comb begin
        rom_cs   = mem_req && state.en && (base_hit || boot_hit);
        rom_addr = {state.page, cpu_addr[PAGE_OFS_W-1:0]};
    end
endmodule

// File: rtl/rom_map_ctl.sv
// Top of the ROM mapping and board control unit. Ties the I/O window decoder,
// the control state and the ROM select together and muxes the status word.
// Assumes read data is only sampled while io_rd is high.
module rom_map_ctl
    import rmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] io_base_cfg,
    input  logic [SEG_W-1:0]  rom_base_cfg,
    input  logic              strap_rom_en,
    input  logic              strap_boot,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              serial_cs,
    input  logic [MEM_AW-1:0] cpu_addr,
    input  logic              mem_req,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr
);
    logic       ctl_we;
    logic       stat_re;
    ctl_state_t state;

    rmc_io_decode u_dec (
        .io_addr   (io_addr),
        .io_base   (io_base_cfg),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .serial_cs (serial_cs),
        .ctl_we    (ctl_we),
        .stat_re   (stat_re)
    );

    rmc_ctl_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_rom_en (strap_rom_en),
        .strap_boot   (strap_boot),
        .ctl_we       (ctl_we),
        .wdata        (io_wdata),
        .state        (state)
    );

    rmc_rom_select u_sel (
        .cpu_addr (cpu_addr),
        .mem_req  (mem_req),
        .rom_base (rom_base_cfg),
        .state    (state),
        .rom_cs   (rom_cs),
        .rom_addr (rom_addr)
    );

    // Status word on a control-offset read, zero everywhere else.
    always_comb begin
        io_rdata = '0;
        if (stat_re) begin
            io_rdata[PAGE_LSB +: PAGE_W] = state.page;
            io_rdata[BIT_EN]             = state.en;
            io_rdata[BIT_BOOT]           = state.boot;
        end
    end

    AST_ROM_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !state.en |-> !rom_cs); // R9
    AST_SERIAL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        serial_cs |-> (io_addr[IO_AW-1:WIN_BITS] == io_base_cfg && !ctl_we)); // R2
    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr[IO_AW-1:WIN_BITS] != io_base_cfg) |-> (io_rdata == '0 && !serial_cs)); // R1
    AST_CS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> mem_req); // R7
endmodule

// File: tb/test_rom_map_ctl.sv
// Bench for rom_map_ctl: directed strap/boot sequences, then seeded random traffic.
module test_rom_map_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  io_base_cfg = 6'd0;
    logic [3:0]  rom_base_cfg = 4'hF;
    logic        strap_rom_en = 1'b0;
    logic        strap_boot = 1'b0;
    logic [7:0]  io_addr = 8'd0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'd0;
    logic [7:0]  io_rdata;
    logic        serial_cs;
    logic [15:0] cpu_addr = 16'd0;
    logic        mem_req = 1'b0;
    logic        rom_cs;
    logic [14:0] rom_addr;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference state.
    logic [2:0] m_page;
    logic       m_en;
    logic       m_boot;

    always #2 clk = ~clk;

    rom_map_ctl i_rom_map_ctl (
        .clk(clk), .rst_n(rst_n), .io_base_cfg(io_base_cfg), .rom_base_cfg(rom_base_cfg),
        .strap_rom_en(strap_rom_en), .strap_boot(strap_boot), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .serial_cs(serial_cs), .cpu_addr(cpu_addr), .mem_req(mem_req),
        .rom_cs(rom_cs), .rom_addr(rom_addr)
    );

    function automatic bit in_win(input logic [7:0] a);
        return a[7:2] == io_base_cfg;
    endfunction

    function automatic bit exp_cs(input logic [15:0] a, input bit req);
        return req && m_en && ((a[15:12] == rom_base_cfg) || (m_boot && a[15:12] == 4'd0));
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [7:0] a, input bit rd);
        if (rd && in_win(a) && a[1:0] == 2'd2) return {m_page, m_en, m_boot, 3'b000};
        return 8'h00;
    endfunction

    function automatic bit exp_ser(input logic [7:0] a, input bit rd, input bit wr);
        return (rd || wr) && in_win(a) && a[1:0] < 2'd2;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check combinational outputs, then update the model.
    task automatic bus(input logic [7:0] ia, input bit rd, input bit wr, input logic [7:0] wd,
                       input logic [15:0] ma, input bit mr, input string req);
        @(negedge clk);
        io_addr = ia; io_rd = rd; io_wr = wr; io_wdata = wd;
        cpu_addr = ma; mem_req = mr;
        #1;
        chk({req, " rom_cs"}, 32'(rom_cs), 32'(exp_cs(ma, mr)));
        chk("R7 rom_addr", 32'(rom_addr), 32'({m_page, ma[11:0]}));
        chk({req, " serial_cs"}, 32'(serial_cs), 32'(exp_ser(ia, rd, wr)));
        chk({req, " io_rdata"}, 32'(io_rdata), 32'(exp_rdata(ia, rd)));
        @(posedge clk);
        if (wr && in_win(ia) && ia[1:0] == 2'd2) begin
            m_page = wd[7:5]; m_en = wd[4]; m_boot = wd[3];
        end
    endtask

    task automatic do_reset(input bit sen, input bit sb);
        @(negedge clk);
        rst_n = 1'b0; strap_rom_en = sen; strap_boot = sb;
        io_rd = 1'b0; io_wr = 1'b0; mem_req = 1'b0;
        repeat (2) @(posedge clk);
        m_page = 3'd0; m_en = sen; m_boot = sb;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    logic [7:0] base_ia;

    initial begin
        int seed = 32'h5EED1234;
        void'($urandom(seed));
        // Strap combinations: reset defaults, overlay and base selects (R3 R8 R9 R5).
        for (int s = 0; s < 4; s++) begin
            do_reset(s[0], s[1]);
            base_ia = {io_base_cfg, 2'd2};
            bus(base_ia, 1'b1, 1'b0, 8'h00, 16'h0123, 1'b1, "R3 R5 R8 R9");
            bus(8'h00, 1'b0, 1'b0, 8'h00, 16'hF456, 1'b1, "R7 R9");
            // Clear boot, keep enable and page 5; address zero must drop next cycle (R8).
            bus(base_ia, 1'b0, 1'b1, {3'd5, s[0], 1'b0, 3'b111}, 16'h0010, 1'b1, "R8 R4");
            bus(base_ia, 1'b1, 1'b0, 8'h00, 16'h0010, 1'b1, "R8 R4 R5");
            bus(8'h00, 1'b0, 1'b0, 8'h00, 16'hFABC, 1'b1, "R7 page");
            // Reserved offset write changes nothing (R6).
            bus({io_base_cfg, 2'd3}, 1'b0, 1'b1, 8'hFF, 16'h0000, 1'b1, "R6");
            bus({io_base_cfg, 2'd3}, 1'b1, 1'b0, 8'h00, 16'h0000, 1'b1, "R6");
            bus(base_ia, 1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, "R6 R5");
        end
        // Relocated window and serial offsets (R1 R2).
        io_base_cfg = 6'h2A;
        bus(8'hA8, 1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, "R2");
        bus(8'hA9, 1'b0, 1'b1, 8'h00, 16'h0000, 1'b0, "R2");
        bus(8'h02, 1'b0, 1'b1, 8'hF8, 16'h0000, 1'b0, "R1");
        bus(8'hAA, 1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, "R1 R5");
        // Random traffic biased toward the window.
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ia;
            logic [1:0] op;
            if (i % 500 == 0) begin
                io_base_cfg = 6'($urandom);
                rom_base_cfg = 4'($urandom);
                do_reset(1'($urandom), 1'($urandom));
            end
            ia = ($urandom % 4 != 0) ? {io_base_cfg, 2'($urandom)} : 8'($urandom);
            op = 2'($urandom % 3);
            bus(ia, op == 2'd1, op == 2'd2, 8'($urandom),
                ($urandom % 2 == 0) ? {($urandom % 2 == 0) ? 4'd0 : rom_base_cfg, 12'($urandom)}
                                    : 16'($urandom),
                1'($urandom), "R1 R2 R4 R7 R8 R9");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule